// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage shift register. It takes a word in one of two ways: as a whole word in a single clock edge, or one bit per edge through a serial input. Whichever way the word arrives, it leaves through one serial output, which is always the value of the last stage. A single select line picks load or shift at each rising edge. A clock enable can freeze the register in either mode. An active-low clear forces every stage to zero at once, without waiting for a clock edge.

A typical use is parallel-to-serial conversion. One load edge captures the word. Eight shift edges then push it out, last stage first. During those eight edges, the bits arriving at the serial input fill the register from the first stage.

Top module: `wser_top`

## Requirements
- R1: With `ce`=1 and `shld`=0 (load), every stage captures `par_in` on the rising edge. Stage i takes `par_in[i]`.
- R2: With `ce`=1 and `shld`=1 (shift), stage i takes the old value of stage i-1 on the rising edge, and stage 0 takes `ser_in`.
- R3: During a load, `ser_in` has no effect on any stage.
- R4: While `clr_n` is 0, every stage is 0 and `ser_out` is 0. This holds from the moment `clr_n` falls, with no clock edge needed.
- R5: `ser_out` always equals stage 7, the last stage. Right after a load it shows `par_in[7]`.
- R6: With `ce`=0, the register keeps its contents across clock edges in both load mode and shift mode.
- R7: A low `clr_n` clears the register even while `ce`=0.
- R8: After one load edge, eight shift edges bring out `par_in[7]` down to `par_in[0]` on `ser_out`. After those eight edges the register holds the eight serial bits taken in meanwhile, and the first of them is in the last stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| ce | input | 1 | Clock enable, active high |
| shld | input | 1 | Mode select: 0 load, 1 shift |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel word, bit i goes to stage i |
| ser_out | output | 1 | Value of the last stage |

## Verification
The assertions assume that `ce`, `shld`, `ser_in` and `par_in` are settled at each rising edge. They also assume that `clr_n` rises only away from an edge, so that the value seen one cycle later reflects a single defined update. The bench changes every input on the falling clock edge and releases `clr_n` mid-cycle, so every edge sees stable values. Its random phase draws all four data and control inputs freely, so load, shift and frozen cycles mix in any order. Directed cases then cover clearing with the enable held off and a full load followed by eight shifts.

// File: rtl/wser_pkg.sv
package wser_pkg;

  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } mode_t;

  // next value of one stage, given its own value, its parallel bit
  // and the bit from the stage before it (or the serial input)
  function automatic logic stage_next(input logic hold_v,
                                      input logic par_v,
                                      input logic up_v,
                                      input logic do_load,
                                      input logic do_shift);
    logic r;
    r = hold_v;
    if (do_load)       r = par_v;
    else if (do_shift) r = up_v;
    return r;
  endfunction

endpackage

// File: rtl/wser_ctrl.sv
module wser_ctrl
  import wser_pkg::*;
(
  input  logic ce,
  input  logic shld,
  output logic load_ev,
  output logic shift_ev
);
  mode_t mode;

  assign mode     = mode_t'(shld);
  assign load_ev  = ce && (mode == MODE_LOAD);
  assign shift_ev = ce && (mode == MODE_SHIFT);
endmodule

// File: rtl/wser_stage.sv
module wser_stage
  import wser_pkg::*;
(
  input  logic clk,
  input  logic clr_n,
  input  logic load_ev,
  input  logic shift_ev,
  input  logic par_bit,
  input  logic up_bit,
  output logic q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= stage_next(q, par_bit, up_bit, load_ev, shift_ev);
  end
endmodule

// File: rtl/wser_top.sv
module wser_top #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ce,
  input  logic             shld,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out
);
  localparam int LAST = WIDTH - 1;

  logic             load_ev;
  logic             shift_ev;
  logic [WIDTH-1:0] q;

  wser_ctrl u_ctrl (
    .ce       (ce),
    .shld     (shld),
    .load_ev  (load_ev),
    .shift_ev (shift_ev)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic up_bit;
    if (i == 0) begin : g_first
      assign up_bit = ser_in;
    end else begin : g_rest
      assign up_bit = q[i-1];
    end
    wser_stage u_stage (
      .clk      (clk),
      .clr_n    (clr_n),
      .load_ev  (load_ev),
      .shift_ev (shift_ev),
      .par_bit  (par_in[i]),
      .up_bit   (up_bit),
      .q        (q[i])
    );
  end

  assign ser_out = q[LAST];

  // R1, R3: a load takes the word and nothing else
  a_r1_load: assert property (@(posedge clk) disable iff (!clr_n)
    load_ev |=> (q == $past(par_in)));

  // R2: a shift moves every stage one step and feeds stage 0 from ser_in
  a_r2_shift: assert property (@(posedge clk) disable iff (!clr_n)
    shift_ev |=> (q == {$past(q[WIDTH-2:0]), $past(ser_in)}));

  // R6: enable off freezes the register
  a_r6_hold: assert property (@(posedge clk) disable iff (!clr_n)
    !ce |=> $stable(q));

  // R4, R7: clear low forces all stages to zero
  always_ff @(posedge clk) begin
    if (!clr_n) begin
      a_r4_clear: assert (q == '0);
    end
  end
endmodule

// File: tb/wser_top_tb.sv
`timescale 1ns/1ps
module wser_top_tb;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       ce = 1'b0;
  logic       shld = 1'b0;
  logic       ser_in = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic       ser_out;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  logic [7:0] model = 8'h00;

  wser_top u_dut (
    .clk(clk), .clr_n(clr_n), .ce(ce), .shld(shld),
    .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] exp_next(input logic [7:0] cur,
                                          input logic e, input logic s,
                                          input logic si, input logic [7:0] pi);
    if (!e)      return cur;
    else if (!s) return pi;
    else         return {cur[6:0], si};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at falling edge, let one rising edge pass, sample 1 ns after it
  task automatic step(input string req, input logic e, input logic s,
                      input logic si, input logic [7:0] pi);
    @(negedge clk);
    ce = e; shld = s; ser_in = si; par_in = pi;
    @(posedge clk);
    model = exp_next(model, e, s, si, pi);
    #1;
    check(req, ser_out, model[7]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // reset state
    #1;
    check("R4 reset", ser_out, 1'b0);
    @(negedge clk); clr_n = 1'b1;

    // R1 R5: load A5, output shows bit 7 at once
    step("R1 R5 load", 1'b1, 1'b0, 1'b0, 8'hA5);
    // R8: eight shifts bring out the word last stage first, serial 1s fill
    for (int i = 0; i < 8; i++) step("R8 R2 shift out", 1'b1, 1'b1, 1'b1, 8'h00);
    // register now all ones from the serial bits
    for (int i = 0; i < 8; i++) step("R8 serial fill", 1'b1, 1'b1, (i % 2 == 0), 8'h00);

    // R3: load with ser_in high, then drain with ser_in low
    step("R3 load ignores ser_in", 1'b1, 1'b0, 1'b1, 8'h3C);
    for (int i = 0; i < 8; i++) step("R3 drain", 1'b1, 1'b1, 1'b0, 8'hFF);

    // R6: enable off in both modes
    step("R1 load", 1'b1, 1'b0, 1'b0, 8'h81);
    for (int i = 0; i < 4; i++) step("R6 hold load mode", 1'b0, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 4; i++) step("R6 hold shift mode", 1'b0, 1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 8; i++) step("R6 R2 after hold", 1'b1, 1'b1, 1'b0, 8'h00);

    // R4 R7: clear mid-cycle with ce off, output falls with no edge
    step("R1 load", 1'b1, 1'b0, 1'b0, 8'hFF);
    @(negedge clk);
    ce = 1'b0;
    #0.5 clr_n = 1'b0;
    #0.5;
    model = 8'h00;
    check("R4 R7 async clear", ser_out, 1'b0);
    @(posedge clk); #1;
    check("R4 clear held over edge", ser_out, 1'b0);
    @(negedge clk); #0.5 clr_n = 1'b1;
    for (int i = 0; i < 8; i++) step("R4 cleared contents", 1'b1, 1'b1, 1'b0, 8'h00);

    // random mix
    for (int i = 0; i < 400; i++)
      step("R1 R2 R6 random", 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));

    // clear during random load/shift traffic with ce on
    @(negedge clk); ce = 1'b1; shld = 1'b0; par_in = 8'hFF;
    #0.5 clr_n = 1'b0; #0.5; model = 8'h00;
    check("R4 clear over load", ser_out, 1'b0);
    @(posedge clk); #1;
    check("R4 clear beats load edge", ser_out, 1'b0);
    @(negedge clk); #0.5 clr_n = 1'b1;
    step("R1 R5 load after clear", 1'b1, 1'b0, 1'b0, 8'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule